// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the card clock of an SD/MMC host from the kernel clock. It also produces a one-cycle update strobe in the kernel clock domain. The command and data output registers of the host use this strobe as an enable, so that they change on the chosen card clock edge. A single configuration word sets the division ratio, the launch edge, clock gating while idle, and the data bus width. The block decodes the bus width and passes it on to the data path.

A divider field of zero selects bypass. In bypass the card clock is the kernel clock itself, gated by a falling-edge enable, and outputs launch on the kernel falling edge. A nonzero divider N gives a card clock with N kernel cycles high and N kernel cycles low, which is the kernel frequency divided by 2N. A new divider value is taken only when a low phase starts, so the high phase in progress always completes at its old length. With power-save set and no bus activity flagged, the card clock holds in its low phase until activity returns.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is asserted, `card_clk_o` is low in both halves of every kernel cycle.
- R2: With the divider field `cfg_word_i[9:0]` = N > 0, the card clock stays high for exactly N kernel cycles and then low for exactly N kernel cycles.
- R3: With the divider field zero and power-save off, `card_clk_o` follows the kernel clock and `upd_stb_o` is high in every cycle.
- R4: In divided mode with the edge-select bit `cfg_word_i[16]` = 0, `upd_stb_o` is high exactly in the kernel cycle just before each card clock rising edge.
- R5: In divided mode with `cfg_word_i[16]` = 1, `upd_stb_o` is high exactly in the kernel cycle just before each card clock falling edge.
- R6: `bus_width_o` is 0 (1-bit bus) when neither width bit is set, 1 (4-bit bus) when only `cfg_word_i[14]` is set, and 2 (8-bit bus) when `cfg_word_i[15]` is set, including when both bits are set.
- R7: In divided mode with power-save `cfg_word_i[12]` = 1 and `bus_busy_i` = 0, the card clock stays low and no strobe is given. The clock resumes once `bus_busy_i` rises.
- R8: A divider value written during a high phase has no effect on the length of that high phase. It sets the length of the low phase that follows.
- R9: The largest divider value, 0x3FF, gives high and low phases of 1023 kernel cycles each.
- R10: In bypass with power-save on and the bus idle, `card_clk_o` stays low and `upd_stb_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_word_i | input | 32 | Configuration word: divider [9:0], power-save [12], 4-bit bus [14], 8-bit bus [15], edge select [16] |
| bus_busy_i | input | 1 | High while command or data activity is in progress |
| card_clk_o | output | 1 | Card clock |
| upd_stb_o | output | 1 | Output-update enable for command and data launch registers |
| bus_width_o | output | 2 | Decoded bus width: 0 = 1 bit, 1 = 4 bits, 2 = 8 bits |

## Verification
The assertions assume that the configuration word and the busy flag are synchronous to the kernel clock. They must change only after a rising edge, so the falling-edge gate in bypass samples a settled level. The stimulus therefore drives every input a short time after the rising edge and holds it for the rest of the cycle. Changes between bypass and divided mode are made only while the card clock is low or gated. A cycle-accurate behavioural model compares the card clock level in both kernel half-cycles, the strobe and the width code in every cycle. Directed runs measure phase lengths at small, changed and maximum divider values.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int unsigned CFG_W_DEF     = 32;
  localparam int unsigned DIV_W_DEF     = 10;
  localparam int unsigned PSAVE_BIT_DEF = 12;
  localparam int unsigned W4_BIT_DEF    = 14;
  localparam int unsigned W8_BIT_DEF    = 15;
  localparam int unsigned EDGE_BIT_DEF  = 16;

  typedef enum logic [1:0] {
    BUS_X1 = 2'd0,
    BUS_X4 = 2'd1,
    BUS_X8 = 2'd2
  } bus_width_e;

  // Wider setting wins when both width bits are present.
  function automatic bus_width_e width_decode(input logic sel4, input logic sel8);
    if (sel8)      return BUS_X8;
    else if (sel4) return BUS_X4;
    else           return BUS_X1;
  endfunction

  // The card clock may run when gating is off or the bus is active.
  function automatic logic clock_allowed(input logic psave, input logic busy);
    return !psave || busy;
  endfunction

endpackage

// File: rtl/sdclk_width_dec.sv
module sdclk_width_dec
  import sdclk_pkg::*;
#(
  parameter int unsigned CFG_W  = CFG_W_DEF,
  parameter int unsigned W4_BIT = W4_BIT_DEF,
  parameter int unsigned W8_BIT = W8_BIT_DEF
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic [1:0]       width_o
);

  bus_width_e width_code;

  always_comb begin
    width_code = width_decode(cfg_i[W4_BIT], cfg_i[W8_BIT]);
    width_o    = width_code;
  end

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             edge_i,
  input  logic             run_i,
  output logic             phase_o,
  output logic             bypass_o,
  output logic             term_o,
  output logic             stall_o,
  output logic             stb_o,
  output logic [DIV_W-1:0] div_held_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             toggle;

  function automatic logic last_count(input logic [DIV_W-1:0] cnt,
                                      input logic [DIV_W-1:0] div);
    return cnt == DIV_W'(div - 1'b1);
  endfunction

  always_comb begin
    bypass_o = (div_q == '0);
    term_o   = !bypass_o && last_count(cnt_q, div_q);
    // A high phase always ends; a low phase may be held by gating.
    toggle   = term_o && (phase_q || run_i);
    stall_o  = term_o && !phase_q && !run_i;
    stb_o    = toggle && (edge_i ? phase_q : !phase_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (bypass_o) begin
      div_q   <= div_i;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (toggle) begin
      phase_q <= !phase_q;
      cnt_q   <= '0;
      if (phase_q) div_q <= div_i;
    end else if (stall_o) begin
      div_q <= div_i;
      cnt_q <= DIV_W'(div_i - 1'b1);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o    = phase_q;
  assign div_held_o = div_q;

endmodule

// File: rtl/sdclk_bypass_gate.sv
module sdclk_bypass_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic gated_clk_o,
  output logic gate_en_o
);

  logic en_q;

  // Captured while the kernel clock is low, so the AND cannot glitch.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_i;
  end

  assign gated_clk_o = clk_i & en_q;
  assign gate_en_o   = en_q;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int unsigned CFG_W     = CFG_W_DEF,
  parameter int unsigned DIV_W     = DIV_W_DEF,
  parameter int unsigned PSAVE_BIT = PSAVE_BIT_DEF,
  parameter int unsigned W4_BIT    = W4_BIT_DEF,
  parameter int unsigned W8_BIT    = W8_BIT_DEF,
  parameter int unsigned EDGE_BIT  = EDGE_BIT_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic             bus_busy_i,
  output logic             card_clk_o,
  output logic             upd_stb_o,
  output logic [1:0]       bus_width_o
);

  logic [DIV_W-1:0] cfg_div;
  logic             cfg_edge;
  logic             cfg_psave;
  logic             run;
  logic             div_phase;
  logic             div_bypass;
  logic             div_term;
  logic             div_stall;
  logic             div_stb;
  logic [DIV_W-1:0] div_held;
  logic             byp_clk;
  logic             byp_en;

  assign cfg_div   = cfg_word_i[DIV_W-1:0];
  assign cfg_edge  = cfg_word_i[EDGE_BIT];
  assign cfg_psave = cfg_word_i[PSAVE_BIT];
  assign run       = clock_allowed(cfg_psave, bus_busy_i);

  sdclk_div_core #(.DIV_W(DIV_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (cfg_div),
    .edge_i     (cfg_edge),
    .run_i      (run),
    .phase_o    (div_phase),
    .bypass_o   (div_bypass),
    .term_o     (div_term),
    .stall_o    (div_stall),
    .stb_o      (div_stb),
    .div_held_o (div_held)
  );

  sdclk_bypass_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .gated_clk_o (byp_clk),
    .gate_en_o   (byp_en)
  );

  sdclk_width_dec #(
    .CFG_W  (CFG_W),
    .W4_BIT (W4_BIT),
    .W8_BIT (W8_BIT)
  ) u_width (
    .cfg_i   (cfg_word_i),
    .width_o (bus_width_o)
  );

  assign card_clk_o = div_bypass ? byp_clk : div_phase;
  assign upd_stb_o  = div_bypass ? run : div_stb;

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int unsigned DIV_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             div_bypass,
  input logic             div_phase,
  input logic             div_term,
  input logic             div_stb,
  input logic [DIV_W-1:0] div_held,
  input logic             cfg_edge,
  input logic             cfg_psave,
  input logic             bus_busy_i
);

  AST_HIGH_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_bypass && div_phase && div_term) |=> !div_phase);  // R2

  AST_STB_BEFORE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_bypass && div_stb && !cfg_edge) |=> $rose(div_phase));  // R4

  AST_STB_BEFORE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_bypass && div_stb && cfg_edge) |=> $fell(div_phase));  // R5

  AST_IDLE_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_bypass && !div_phase && div_term && cfg_psave && !bus_busy_i) |=> !div_phase);  // R7

  AST_DIV_HELD_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_bypass && div_phase && !div_term) |=> $stable(div_held));  // R8

endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_bypass (div_bypass),
  .div_phase  (div_phase),
  .div_term   (div_term),
  .div_stb    (div_stb),
  .div_held   (div_held),
  .cfg_edge   (cfg_edge),
  .cfg_psave  (cfg_psave),
  .bus_busy_i (bus_busy_i)
);

// File: tb/sdclk_gen_tb.sv
`timescale 1ns/100ps
module sdclk_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic        busy = 1'b0;
  logic        card;
  logic        stb;
  logic [1:0]  bw;

  sdclk_gen u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_word_i  (cfg),
    .bus_busy_i  (busy),
    .card_clk_o  (card),
    .upd_stb_o   (stb),
    .bus_width_o (bw)
  );

  always #2 clk = ~clk;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int r_div = 0;
  int r_left = 0;
  bit r_ph = 0;
  bit r_en = 0;
  int nd;
  bit term;
  bit e_stb;
  int e_bw;

  function automatic bit run_now();
    return !cfg[12] || busy;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) r_en = 0;
    else        r_en = run_now();
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      r_div = 0; r_ph = 0; r_left = 0;
    end else begin
      nd   = int'(cfg[9:0]);
      term = (r_div != 0) && (r_left == 1);
      if (r_div == 0) begin
        r_div = nd; r_ph = 0; r_left = nd;
      end else if (term && (r_ph || run_now())) begin
        if (r_ph) r_div = nd;
        r_ph   = !r_ph;
        r_left = r_div;
      end else if (term) begin
        r_div = nd; r_left = 1;
      end else begin
        r_left = r_left - 1;
      end
    end
    #1.5;
    if (rst_n) begin
      if (r_div == 0) chk(card === r_en, "R3 bypass high half", card, r_en);
      else            chk(card === r_ph, "R2 card level high half", card, r_ph);
    end
    #2;
    if (rst_n) begin
      if (r_div == 0) begin
        chk(card === 1'b0, "R3 bypass low half", card, 0);
        chk(stb === run_now(), "R3 bypass strobe", stb, run_now());
      end else begin
        chk(card === r_ph, "R2 card level low half", card, r_ph);
        term  = (r_left == 1);
        e_stb = term && (r_ph || run_now()) && (cfg[16] ? r_ph : !r_ph);
        if (cfg[16]) chk(stb === e_stb, "R5 strobe", stb, e_stb);
        else         chk(stb === e_stb, "R4 strobe", stb, e_stb);
      end
      e_bw = cfg[15] ? 2 : (cfg[14] ? 1 : 0);
      chk(bw === 2'(e_bw), "R6 width", bw, e_bw);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mk(input int div, input bit edge_sel, input bit ps,
                                     input bit w4, input bit w8);
    logic [31:0] w;
    w = '0;
    w[9:0] = 10'(div);
    w[12] = ps; w[14] = w4; w[15] = w8; w[16] = edge_sel;
    return w;
  endfunction

  task automatic drive(input logic [31:0] w, input bit b);
    @(posedge clk); #0.5;
    cfg = w; busy = b;
  endtask

  task automatic samp();
    @(posedge clk); #3.5;
  endtask

  // Wait for a transition into level lvl, then count its length in cycles.
  task automatic run_len(input bit lvl, output int n);
    int guard;
    guard = 0;
    samp();
    while (card === lvl && guard < 5000) begin samp(); guard++; end
    while (card !== lvl && guard < 5000) begin samp(); guard++; end
    n = 0;
    while (card === lvl && guard < 5000) begin n++; samp(); guard++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int n;
    int guard;
    bit prev;
    // R1: reset holds the card clock low in both halves
    repeat (3) begin
      @(posedge clk); #1.5;
      chk(card === 1'b0, "R1 reset high half", card, 0);
      #2;
      chk(card === 1'b0, "R1 reset low half", card, 0);
    end
    @(posedge clk); #0.5; rst_n = 1'b1;

    // R3: bypass running
    drive(mk(0, 0, 0, 0, 0), 0);
    repeat (2) samp();
    @(posedge clk); #1.5;
    chk(card === 1'b1, "R3 bypass clock high", card, 1);
    #2;
    chk(stb === 1'b1, "R3 bypass strobe on", stb, 1);

    // R10: bypass gated while idle
    drive(mk(0, 0, 1, 0, 0), 0);
    repeat (2) samp();
    @(posedge clk); #1.5;
    chk(card === 1'b0, "R10 bypass gated clock", card, 0);
    #2;
    chk(stb === 1'b0, "R10 bypass strobe off", stb, 0);
    drive(mk(0, 0, 0, 0, 0), 0);

    // R6: width patterns
    for (int k = 0; k < 4; k++) begin
      drive(mk(0, 0, 0, k[0], k[1]), 0);
      #3;
      chk(bw === 2'(k[1] ? 2 : (k[0] ? 1 : 0)), "R6 width pattern", bw, k[1] ? 2 : (k[0] ? 1 : 0));
    end

    // R2: divide by 3
    drive(mk(3, 0, 0, 0, 0), 0);
    run_len(1'b1, n);
    chk(n == 3, "R2 high phase length", n, 3);
    run_len(1'b0, n);
    chk(n == 3, "R2 low phase length", n, 3);

    // R4: strobe precedes rising edge
    guard = 0;
    samp();
    while (stb !== 1'b1 && guard < 100) begin samp(); guard++; end
    prev = card;
    samp();
    chk(prev == 1'b0 && card === 1'b1, "R4 rise after strobe", card, 1);

    // R5: strobe precedes falling edge
    drive(mk(3, 1, 0, 0, 0), 0);
    guard = 0;
    samp();
    while (stb !== 1'b1 && guard < 100) begin samp(); guard++; end
    prev = card;
    samp();
    chk(prev == 1'b1 && card === 1'b0, "R5 fall after strobe", card, 0);

    // R7: power-save holds the clock low, then resumes
    drive(mk(2, 0, 1, 0, 0), 0);
    repeat (10) samp();
    n = 0;
    repeat (20) begin samp(); if (card === 1'b1 || stb === 1'b1) n++; end
    chk(n == 0, "R7 held low while idle", n, 0);
    drive(mk(2, 0, 1, 0, 0), 1);
    run_len(1'b1, n);
    chk(n == 2, "R7 resumed high phase", n, 2);

    // R8: divider change in a high phase
    drive(mk(4, 0, 0, 0, 0), 1);
    guard = 0;
    samp();
    while (card === 1'b1 && guard < 100) begin samp(); guard++; end
    while (card !== 1'b1 && guard < 100) begin samp(); guard++; end
    n = 1;
    @(posedge clk); #0.5;
    cfg = mk(1, 0, 0, 0, 0);
    #3;
    while (card === 1'b1 && n < 100) begin n++; samp(); end
    chk(n == 4, "R8 high phase keeps old divider", n, 4);
    n = 0;
    while (card === 1'b0 && n < 100) begin n++; samp(); end
    chk(n == 1, "R8 low phase uses new divider", n, 1);

    // R9: maximum divider
    drive(mk(1023, 0, 0, 0, 0), 0);
    run_len(1'b1, n);
    chk(n == 1023, "R9 max high phase", n, 1023);
    run_len(1'b0, n);
    chk(n == 1023, "R9 max low phase", n, 1023);

    done = 1;
    finish_run();
  end

endmodule